// File: doc/BRIEF.md
# Sticky Event Status Flag Register

An 8-bit status register for a real-time-clock style device. It collects five kinds of condition: time-update, fixed-cycle timer and alarm interrupt events, plus two supply-integrity conditions. The integrity conditions are internal data loss and a halt of temperature compensation. Each condition arrives as a one-cycle pulse that is already synchronous to the register clock. The pulse sets the condition's own bit, and the bit stays set until software writes a zero to it.

Writing a one to a flag does nothing. The register is therefore not write-one-to-clear. Software can clear a chosen subset of flags by writing zeros only at those positions and ones everywhere else. Three positions are reserved: they ignore writes and always read zero.

On power-up the two integrity flags come up set. This tells software that register contents must be reinitialised and that compensation status is unknown. The three interrupt flags have no defined power-up value. This model resets them to 0, and software must not rely on that. Each flag is also exported on its own pin, so downstream interrupt logic can combine it with an enable bit.

Top module: `sflag_reg`

## Requirements
- R1: Flag positions in `rd_data` are: update at bit 5, timer at bit 4, alarm at bit 3, data-loss at bit 1, compensation-stop at bit 0.
- R2: Bits 7, 6 and 2 of `rd_data` always read 0, whatever has been written to them.
- R3: A one-cycle event pulse sets its flag, and the flag reads 1 from the clock edge that samples the pulse onward.
- R4: A set flag stays 1 until a write (`wr_en`=1) carries 0 at that flag's bit position. That write clears the flag at the same clock edge, and flags whose write-data bit is 1 are left unchanged.
- R5: Writing 1 to a flag bit has no effect. A cleared flag stays 0 and a set flag stays 1.
- R6: After synchronous reset, the data-loss and compensation-stop flags read 1 and the reserved bits read 0. The update, timer and alarm flags are undefined after reset and are not checked until their first event or clearing write.
- R7: When an event pulse and a clearing write to the same flag occur in the same cycle, the event wins and the flag reads 1 afterwards.
- R8: Each per-flag output pin always equals that flag's bit in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| evt_update | input | 1 | Time-update event pulse |
| evt_timer | input | 1 | Fixed-cycle timer event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_dataloss | input | 1 | Internal data-loss event pulse |
| evt_compstop | input | 1 | Temperature-compensation-stop event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 at a flag position clears that flag |
| rd_data | output | 8 | Register read value, reserved bits forced to 0 |
| flag_update | output | 1 | Update flag |
| flag_timer | output | 1 | Timer flag |
| flag_alarm | output | 1 | Alarm flag |
| flag_dataloss | output | 1 | Data-loss flag |
| flag_compstop | output | 1 | Compensation-stop flag |

## Verification
Every result is due one clock edge after its stimulus. An event pulse or a write applied before edge k shows on the flag pins and on `rd_data` right after edge k, because the read path has no register of its own. The bench drives inputs on the falling edge and lets one rising edge update its own model. It then compares on the next falling edge, so each check sees exactly one edge of effect. Flags that reset leaves undefined are masked out of the comparison until an event or a clearing write has given them a known value.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

  // Width of the host-visible register
  localparam int unsigned REG_W     = 8;
  // Number of sticky flags held
  localparam int unsigned NUM_FLAGS = 5;

  // Flag index order used across the block
  typedef enum int unsigned {
    FI_COMPSTOP = 0,
    FI_DATALOSS = 1,
    FI_ALARM    = 2,
    FI_TIMER    = 3,
    FI_UPDATE   = 4
  } flag_idx_e;

  // Bit position of each flag inside the register (decoded by software)
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{0, 1, 3, 4, 5};

  // Power-on value of each flag, indexed as flag_idx_e
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 5'b00011;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

endpackage

// File: rtl/sflag_cell.sv
module sflag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // Event has priority over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/sflag_wdec.sv
module sflag_wdec
  import sflag_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [NF-1:0] clr_o
);

  // A zero at a flag's position clears it; a one is ignored
  for (genvar i = 0; i < NF; i++) begin : g_dec
    localparam int unsigned P = FLAG_POS[i];
    assign clr_o[i] = wr_en & ~wr_data[P];
  end

endmodule

// File: rtl/sflag_readback.sv
module sflag_readback
  import sflag_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic [NF-1:0] flags_i,
  output logic [W-1:0]  rd_o
);

  // Positions not owned by a flag stay zero
  always_comb begin
    rd_o = '0;
    for (int i = 0; i < int'(NF); i++) begin
      rd_o[FLAG_POS[i]] = flags_i[i];
    end
  end

endmodule

// File: rtl/sflag_reg.sv
module sflag_reg
  import sflag_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_update,
  input  logic         evt_timer,
  input  logic         evt_alarm,
  input  logic         evt_dataloss,
  input  logic         evt_compstop,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         flag_update,
  output logic         flag_timer,
  output logic         flag_alarm,
  output logic         flag_dataloss,
  output logic         flag_compstop
);

  flag_vec_t evt;
  flag_vec_t clr;
  flag_vec_t flags;

  assign evt[FI_COMPSTOP] = evt_compstop;
  assign evt[FI_DATALOSS] = evt_dataloss;
  assign evt[FI_ALARM]    = evt_alarm;
  assign evt[FI_TIMER]    = evt_timer;
  assign evt[FI_UPDATE]   = evt_update;

  sflag_wdec #(.W(W), .NF(NUM_FLAGS)) u_wdec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sflag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt[i]),
      .clr_i (clr[i]),
      .q_o   (flags[i])
    );
  end

  sflag_readback #(.W(W), .NF(NUM_FLAGS)) u_rb (
    .flags_i (flags),
    .rd_o    (rd_data)
  );

  assign flag_compstop = flags[FI_COMPSTOP];
  assign flag_dataloss = flags[FI_DATALOSS];
  assign flag_alarm    = flags[FI_ALARM];
  assign flag_timer    = flags[FI_TIMER];
  assign flag_update   = flags[FI_UPDATE];

endmodule

// File: rtl/sflag_chk.sv
module sflag_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] evt,    // {update, timer, alarm, dataloss, compstop}
  input logic [4:0] flg,    // same order, from the flag pins
  input logic [4:0] rdf,    // same order, from rd_data bits 5,4,3,1,0
  input logic       wr_en,
  input logic [4:0] wdf     // same order, from wr_data bits 5,4,3,1,0
);

  logic [4:0] clr_req;
  assign clr_req = wr_en ? ~wdf : 5'b0;

  // R3 / R7: a pulsed event leaves its flag set after the edge
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flg & $past(evt)) == $past(evt)));

  // R4: a set flag only drops when a clearing write hit it
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flg) & ~$past(clr_req) & ~flg) == 5'b0));

  // R5: a clear flag never rises without an event, writes of 1 included
  p_w1_nop_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~$past(flg) & ~$past(evt) & flg) == 5'b0));

  // R8: pins and read data agree
  p_pins_match_r8: assert property (@(posedge clk) disable iff (rst)
    flg == rdf);

endmodule

bind sflag_reg sflag_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt   ({evt_update, evt_timer, evt_alarm, evt_dataloss, evt_compstop}),
  .flg   ({flag_update, flag_timer, flag_alarm, flag_dataloss, flag_compstop}),
  .rdf   ({rd_data[5], rd_data[4], rd_data[3], rd_data[1], rd_data[0]}),
  .wr_en (wr_en),
  .wdf   ({wr_data[5], wr_data[4], wr_data[3], wr_data[1], wr_data[0]})
);

// File: tb/tb_sflag_reg.sv
module tb_sflag_reg;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ev  = '0;  // {update, timer, alarm, dataloss, compstop}
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic f_upd, f_tim, f_alm, f_dl, f_cs;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Bench model: expected register and mask of bits with a defined value
  logic [7:0] exp_reg;
  logic [7:0] known;

  localparam int POS [5] = '{0, 1, 3, 4, 5}; // ev index -> register bit

  always #10 clk = ~clk; // 50 MHz

  sflag_reg dut (
    .clk(clk), .rst(rst),
    .evt_update(ev[4]), .evt_timer(ev[3]), .evt_alarm(ev[2]),
    .evt_dataloss(ev[1]), .evt_compstop(ev[0]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .flag_update(f_upd), .flag_timer(f_tim), .flag_alarm(f_alm),
    .flag_dataloss(f_dl), .flag_compstop(f_cs)
  );

  function automatic logic [7:0] model_next(input logic [7:0] cur,
      input logic [4:0] e, input logic we, input logic [7:0] wd);
    logic [7:0] n = cur;
    for (int i = 0; i < 5; i++) begin
      if (e[i])             n[POS[i]] = 1'b1;
      else if (we && !wd[POS[i]]) n[POS[i]] = 1'b0;
    end
    return n & 8'h3B;
  endfunction

  function automatic logic [7:0] known_next(input logic [7:0] k,
      input logic [4:0] e, input logic we, input logic [7:0] wd);
    logic [7:0] n = k;
    for (int i = 0; i < 5; i++)
      if (e[i] || (we && !wd[POS[i]])) n[POS[i]] = 1'b1;
    return n;
  endfunction

  task automatic check(input string req);
    logic [7:0] pins;
    pins = {2'b00, f_upd, f_tim, f_alm, 1'b0, f_dl, f_cs};
    vectors++;
    if ((rd_data & known) !== (exp_reg & known)) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h mask=%h", req,
               rd_data, exp_reg, known);
    end
    vectors++;
    if ((pins & known) !== (exp_reg & known)) begin
      fails++;
      $display("FAIL %s (R8 pins) actual=%h expected=%h mask=%h", req,
               pins, exp_reg, known);
    end
  endtask

  // Drive at falling edge, one rising edge takes effect, sample at next fall
  task automatic cyc(input logic [4:0] e, input logic we, input logic [7:0] wd);
    ev = e; wr_en = we; wr_data = wd;
    @(posedge clk);
    exp_reg = model_next(exp_reg, e, we, wd);
    known   = known_next(known, e, we, wd);
    @(negedge clk);
    ev = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_reg = 8'h03;
    known   = 8'hC7;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset();
    check("R6 reset defaults");

    // Clear everything: writing all zeros
    cyc(5'b0, 1'b1, 8'h00);
    check("R4 clear all");
    if (rd_data !== 8'h00) begin
      fails++; $display("FAIL R4 actual=%h expected=00", rd_data);
    end
    vectors++;

    // Each event alone lands at its own bit
    for (int i = 0; i < 5; i++) begin
      cyc(5'b1 << i, 1'b0, 8'h00);
      vectors++;
      if (rd_data !== (8'h01 << POS[i])) begin
        fails++;
        $display("FAIL R1/R3 flag %0d actual=%h expected=%h", i, rd_data,
                 8'h01 << POS[i]);
      end
      check("R3 event sets");
      cyc(5'b0, 1'b1, 8'h00);
    end

    // Writing ones sets nothing
    cyc(5'b0, 1'b1, 8'hFF);
    check("R5 write ones on cleared flags");
    // Set all, then write ones: nothing clears
    cyc(5'b11111, 1'b0, 8'h00);
    check("R3 all events");
    cyc(5'b0, 1'b1, 8'hFF);
    check("R5 write ones on set flags");
    // Selective clear of timer only
    cyc(5'b0, 1'b1, 8'hEF);
    check("R4 selective clear timer");
    // Reserved bits written with one read zero
    cyc(5'b0, 1'b1, 8'hC4 | 8'h3B);
    check("R2 reserved bits");
    vectors++;
    if (rd_data[7:6] !== 2'b00 || rd_data[2] !== 1'b0) begin
      fails++; $display("FAIL R2 actual=%h expected reserved=0", rd_data);
    end
    // Event and clearing write together: event wins
    cyc(5'b10001, 1'b1, 8'h00);
    check("R7 event beats clear");
    // Hold with idle cycles
    cyc(5'b0, 1'b0, 8'h00);
    cyc(5'b0, 1'b0, 8'h00);
    check("R4 hold while idle");

    // Reset mid-run restores integrity flags
    do_reset();
    check("R6 reset again");

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] e;
      for (int b = 0; b < 5; b++) e[b] = ($urandom % 8) == 0;
      cyc(e, ($urandom % 2) == 0, 8'($urandom));
      check("R3/R4/R5/R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule